// File: doc/BRIEF.md
# Memory dependence wakeup tracker

This block sits beside the issue logic of an out-of-order core. It holds every in-flight load, store and barrier, and it decides when each load or store may be handed to the ready list. An entry is allocated when the instruction is dispatched. The entry records a sequence number, a thread ID and a kind. A load or store becomes ready only when two things are true: its source registers are available, and the store or barrier it depends on has completed.

Each load or store picks its producer at insert time. An active barrier takes precedence over the predicted producing store: a full barrier holds back both loads and stores, while a write barrier holds back only stores. When a store or barrier completes, every waiting dependent is released in the same cycle. A squash removes the younger entries of one thread. Ready entries leave one per cycle through a valid/ready stream that carries the slot index and the sequence number. Every later command addresses an entry by the slot index that was reported when the entry was inserted.

Top module: `memdep_tracker`

## Requirements
- R1: After reset the table holds no entry, `rdy_valid` is 0, `ins_full` is 0 and `ins_slot` is 0.
- R2: An insert takes the lowest-numbered free slot, and `ins_slot` reports that slot while the insert is presented. `ins_full` is 1 exactly when all 16 slots are occupied. An insert presented while `ins_full` is 1 is ignored.
- R3: The kind field is encoded as 0 load, 1 store, 2 full barrier and 3 write barrier. The producer of a speculative load is the load-barrier sequence number while a load barrier is active. The producer of a speculative store is the store-barrier sequence number while a store barrier is active. Otherwise the producer is `ins_pred_seq`, and 0 means no producer.
- R4: If no valid store or barrier holds the producer sequence number, the new entry is memory-dependence-ready at once. This includes a store or barrier that is being completed or squashed in the same cycle.
- R5: A speculative load or store is offered on the ready output only when both its register-ready flag and its memory-dependence-ready flag are set. Whichever flag arrives second makes it visible in the cycle after that clock edge.
- R6: Completing a store or barrier sets the memory-dependence-ready flag of all of its dependents in one cycle. The dependents that are already register-ready become ready together.
- R7: A full barrier sets both the load-barrier and the store-barrier register to its sequence number. A write barrier sets only the store-barrier register.
- R8: On completion, a barrier clears each barrier register it owns only if that register still holds the barrier's own sequence number.
- R9: A squash with thread T and sequence S removes every entry of thread T whose sequence number is greater than S, unsigned. Entries of other threads and older entries are left untouched, and the freed slots can be reused.
- R10: A non-speculative insert ignores barriers and the producer. Its entry is offered on the ready output only after a non-speculative-ready command for its slot.
- R11: The ready output offers the lowest-indexed pending entry. It keeps `rdy_valid` high until `rdy_accept` is seen, and it offers each entry once. Barriers never appear on it.
- R12: A completion frees its slot, and the slot can be allocated again from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | Insert an entry this cycle |
| ins_kind | input | 2 | 0 load, 1 store, 2 full barrier, 3 write barrier |
| ins_nonspec | input | 1 | Entry waits for a non-speculative-ready command |
| ins_seq | input | SEQ_W | Sequence number of the new entry |
| ins_tid | input | TID_W | Thread ID of the new entry |
| ins_pred_seq | input | SEQ_W | Predicted producing store, 0 for none |
| ins_regs_ok | input | 1 | Source registers already available |
| ins_full | output | 1 | No free slot; an insert is ignored |
| ins_slot | output | IDX_W | Slot the presented insert will take |
| regs_valid | input | 1 | Register-ready notify |
| regs_slot | input | IDX_W | Slot of the notify |
| nsr_valid | input | 1 | Non-speculative-ready command |
| nsr_slot | input | IDX_W | Slot of the command |
| cmp_valid | input | 1 | Completion (wakes dependents of stores and barriers, frees slot) |
| cmp_slot | input | IDX_W | Slot that completes |
| sq_valid | input | 1 | Squash command |
| sq_tid | input | TID_W | Thread to squash |
| sq_seq | input | SEQ_W | Squash point; younger entries are removed |
| rdy_valid | output | 1 | A ready entry is offered |
| rdy_accept | input | 1 | Consumer takes the offered entry |
| rdy_slot | output | IDX_W | Slot of the offered entry |
| rdy_seq | output | SEQ_W | Sequence number of the offered entry |

## Verification
Two pairs of functions can fall in the same cycle. In the first pair, a store completes in the same cycle that a new load is inserted naming that store as its producer. The bench drives both on one edge and expects the load to be offered in the very next cycle, not left waiting forever on a dependent vector that has already been drained. In the second pair, a producer wakes a dependent on the same edge that the dependent's register-ready notify arrives. The bench drives both together and expects the dependent on the ready output one cycle later.

// File: rtl/memdep_pkg.sv
// Shared types for the memory dependence wakeup tracker.
// Assumes: kind encoding is fixed by the insert port (bit 1 set = barrier).
package memdep_pkg;

    typedef enum logic [1:0] {
        MK_LOAD    = 2'd0,
        MK_STORE   = 2'd1,
        MK_FULLBAR = 2'd2,
        MK_WRBAR   = 2'd3
    } mem_kind_e;

    // Per-slot control state; sequence number and thread are held apart
    // because their widths are parameters.
    typedef struct packed {
        logic      live;     // slot occupied
        logic      nonspec;  // waits for explicit non-speculative ready
        logic      regs_ok;  // source registers available
        logic      dep_ok;   // producer resolved
        logic      ns_go;    // non-speculative ready received
        logic      sent;     // already handed to the ready output
        mem_kind_e kind;
    } slot_state_t;

endpackage

// File: rtl/memdep_lowest_pick.sv
// Lowest-index selector: reports whether any request bit is set and the
// index of the lowest one. Purely combinational.
// Assumes: N >= 2.
module memdep_lowest_pick #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top so the lowest set bit is the last one written.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/memdep_barrier_regs.sv
// Load-barrier and store-barrier registers. A full barrier arms both, and a
// write barrier arms only the store side. A completing barrier disarms a side
// only while that side still holds its own sequence number.
// Assumes: at most one set and one clear per cycle; a set wins over a clear.
module memdep_barrier_regs
    import memdep_pkg::*;
#(
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_valid,
    input  mem_kind_e        set_kind,
    input  logic [SEQ_W-1:0] set_seq,
    input  logic             clr_valid,
    input  mem_kind_e        clr_kind,
    input  logic [SEQ_W-1:0] clr_seq,
    output logic             ld_act,
    output logic [SEQ_W-1:0] ld_seq,
    output logic             st_act,
    output logic [SEQ_W-1:0] st_seq
);

    logic set_full, clr_full, clr_any;

    // Decode which barrier kinds are involved this cycle.
    always_comb begin
        set_full = set_valid && (set_kind == MK_FULLBAR);
        clr_full = clr_valid && (clr_kind == MK_FULLBAR);
        clr_any  = clr_valid && (clr_kind == MK_FULLBAR || clr_kind == MK_WRBAR);
    end

    // Update the load-barrier register: conditional clear, then arm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_act <= 1'b0;
            ld_seq <= '0;
        end else begin
            if (clr_full && ld_seq == clr_seq) ld_act <= 1'b0;
            if (set_full) begin
                ld_act <= 1'b1;
                ld_seq <= set_seq;
            end
        end
    end

    // Update the store-barrier register: conditional clear, then arm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_act <= 1'b0;
            st_seq <= '0;
        end else begin
            if (clr_any && st_seq == clr_seq) st_act <= 1'b0;
            if (set_valid) begin
                st_act <= 1'b1;
                st_seq <= set_seq;
            end
        end
    end

    // R8
    ld_clear_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_full && ld_act && ld_seq == clr_seq && !set_full) |=> !ld_act);

    // R8
    st_keep_on_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_valid && st_act && st_seq != clr_seq) |=> st_act);

    // R7
    wrbar_spares_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_valid && set_kind == MK_WRBAR && !clr_valid)
        |=> (ld_act == $past(ld_act)) && (ld_seq == $past(ld_seq)) && st_act);

endmodule

// File: rtl/memdep_dep_matrix.sv
// Dependent vectors: row p holds one bit per slot waiting on producer p.
// Allocating a slot clears its column so no stale link survives reuse;
// a wake reads the producer's row out and empties it.
// Assumes: the caller never links to the producer it wakes in the same cycle.
module memdep_dep_matrix #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_valid,
    input  logic [IDX_W-1:0] alloc_slot,
    input  logic             link_valid,
    input  logic [IDX_W-1:0] link_prod,
    input  logic             wake_valid,
    input  logic [IDX_W-1:0] wake_slot,
    output logic [N-1:0]     wake_vec
);

    logic [N-1:0] rows_q [N];
    logic [N-1:0] col_bit;

    // One-hot column of the slot being allocated this cycle.
    always_comb begin
        col_bit = '0;
        if (alloc_valid) col_bit[alloc_slot] = 1'b1;
    end

    // Row read-out of the completing producer.
    always_comb begin
        wake_vec = wake_valid ? rows_q[wake_slot] : '0;
    end

    for (genvar r = 0; r < N; r++) begin : g_row
        // Maintain one producer row: empty on wake, else drop the reused
        // column and add a fresh link.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rows_q[r] <= '0;
            end else if (wake_valid && wake_slot == IDX_W'(r)) begin
                rows_q[r] <= '0;
            end else if (link_valid && link_prod == IDX_W'(r)) begin
                rows_q[r] <= (rows_q[r] & ~col_bit) | col_bit;
            end else begin
                rows_q[r] <= rows_q[r] & ~col_bit;
            end
        end
    end

    // R6
    wake_drains_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |=> rows_q[$past(wake_slot)] == '0);

endmodule

// File: rtl/memdep_tracker.sv
// Memory dependence wakeup tracker: a table of in-flight loads, stores and
// barriers. It resolves each entry's producer at insert, joins register and
// dependence readiness, and streams ready loads and stores out one per cycle.
// Assumes: sequence numbers are unique among live entries and nonzero;
// commands name live slots; one completion per cycle.
module memdep_tracker
    import memdep_pkg::*;
#(
    parameter int SLOTS = 16,
    parameter int SEQ_W = 16,
    parameter int TID_W = 2,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_valid,
    input  logic [1:0]       ins_kind,
    input  logic             ins_nonspec,
    input  logic [SEQ_W-1:0] ins_seq,
    input  logic [TID_W-1:0] ins_tid,
    input  logic [SEQ_W-1:0] ins_pred_seq,
    input  logic             ins_regs_ok,
    output logic             ins_full,
    output logic [IDX_W-1:0] ins_slot,
    input  logic             regs_valid,
    input  logic [IDX_W-1:0] regs_slot,
    input  logic             nsr_valid,
    input  logic [IDX_W-1:0] nsr_slot,
    input  logic             cmp_valid,
    input  logic [IDX_W-1:0] cmp_slot,
    input  logic             sq_valid,
    input  logic [TID_W-1:0] sq_tid,
    input  logic [SEQ_W-1:0] sq_seq,
    output logic             rdy_valid,
    input  logic             rdy_accept,
    output logic [IDX_W-1:0] rdy_slot,
    output logic [SEQ_W-1:0] rdy_seq
);

    slot_state_t      ent_q [SLOTS];
    logic [SEQ_W-1:0] seq_q [SLOTS];
    logic [TID_W-1:0] tid_q [SLOTS];

    logic [SLOTS-1:0] live_vec, kill_vec, leave_vec, prod_hits, cand_vec, wake_vec;
    logic             free_any, prod_found, ins_fire, rdy_fire;
    logic             ins_is_bar, cmp_live, cmp_wakes, bar_clr;
    logic [IDX_W-1:0] free_idx, prod_idx, rdy_idx;
    logic [SEQ_W-1:0] prod_seq;
    mem_kind_e        ins_kind_e, cmp_kind;
    logic             ld_act, st_act;
    logic [SEQ_W-1:0] ld_seq, st_seq;

    // Packed views of the per-slot state used by the selectors.
    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            live_vec[i] = ent_q[i].live;
            kill_vec[i] = sq_valid && ent_q[i].live && tid_q[i] == sq_tid
                          && seq_q[i] > sq_seq;
            cand_vec[i] = ent_q[i].live && !ent_q[i].sent && !ent_q[i].kind[1]
                          && (ent_q[i].nonspec ? ent_q[i].ns_go
                                               : (ent_q[i].regs_ok && ent_q[i].dep_ok));
        end
    end

    // Decode the completing slot.
    always_comb begin
        cmp_kind  = ent_q[cmp_slot].kind;
        cmp_live  = cmp_valid && ent_q[cmp_slot].live;
        cmp_wakes = cmp_live && cmp_kind != MK_LOAD;
        bar_clr   = cmp_live && cmp_kind[1];
        leave_vec = kill_vec;
        if (cmp_live) leave_vec[cmp_slot] = 1'b1;
    end

    // Pick the producer sequence number: an active barrier beats the prediction.
    always_comb begin
        ins_kind_e = mem_kind_e'(ins_kind);
        ins_is_bar = ins_kind_e[1];
        if (ins_kind_e == MK_LOAD && ld_act)       prod_seq = ld_seq;
        else if (ins_kind_e == MK_STORE && st_act) prod_seq = st_seq;
        else                                       prod_seq = ins_pred_seq;
        for (int i = 0; i < SLOTS; i++) begin
            prod_hits[i] = ent_q[i].live && !leave_vec[i] && ent_q[i].kind != MK_LOAD
                           && seq_q[i] == prod_seq && prod_seq != '0;
        end
    end

    memdep_lowest_pick #(.N(SLOTS), .IDX_W(IDX_W)) i_free_pick (
        .req (~live_vec),
        .any (free_any),
        .idx (free_idx)
    );

    memdep_lowest_pick #(.N(SLOTS), .IDX_W(IDX_W)) i_prod_pick (
        .req (prod_hits),
        .any (prod_found),
        .idx (prod_idx)
    );

    memdep_lowest_pick #(.N(SLOTS), .IDX_W(IDX_W)) i_rdy_pick (
        .req (cand_vec),
        .any (rdy_valid),
        .idx (rdy_idx)
    );

    // Insert and ready-stream handshakes.
    always_comb begin
        ins_full = !free_any;
        ins_slot = free_idx;
        ins_fire = ins_valid && free_any;
        rdy_fire = rdy_valid && rdy_accept;
        rdy_slot = rdy_idx;
        rdy_seq  = seq_q[rdy_idx];
    end

    memdep_barrier_regs #(.SEQ_W(SEQ_W)) i_barriers (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_valid (ins_fire && ins_is_bar),
        .set_kind  (ins_kind_e),
        .set_seq   (ins_seq),
        .clr_valid (bar_clr),
        .clr_kind  (cmp_kind),
        .clr_seq   (seq_q[cmp_slot]),
        .ld_act    (ld_act),
        .ld_seq    (ld_seq),
        .st_act    (st_act),
        .st_seq    (st_seq)
    );

    memdep_dep_matrix #(.N(SLOTS), .IDX_W(IDX_W)) i_deps (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_valid (ins_fire),
        .alloc_slot  (free_idx),
        .link_valid  (ins_fire && !ins_nonspec && !ins_is_bar && prod_found),
        .link_prod   (prod_idx),
        .wake_valid  (cmp_wakes),
        .wake_slot   (cmp_slot),
        .wake_vec    (wake_vec)
    );

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        // Keep one slot: allocate, free, and collect its readiness events.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[g] <= '{live: 1'b0, nonspec: 1'b0, regs_ok: 1'b0, dep_ok: 1'b0,
                              ns_go: 1'b0, sent: 1'b0, kind: MK_LOAD};
                seq_q[g] <= '0;
                tid_q[g] <= '0;
            end else if (ins_fire && free_idx == IDX_W'(g)) begin
                ent_q[g].live    <= 1'b1;
                ent_q[g].nonspec <= ins_nonspec;
                ent_q[g].regs_ok <= ins_regs_ok;
                ent_q[g].dep_ok  <= ins_nonspec || ins_is_bar || !prod_found;
                ent_q[g].ns_go   <= 1'b0;
                ent_q[g].sent    <= 1'b0;
                ent_q[g].kind    <= ins_kind_e;
                seq_q[g]         <= ins_seq;
                tid_q[g]         <= ins_tid;
            end else begin
                if (leave_vec[g]) ent_q[g].live <= 1'b0;
                if (regs_valid && regs_slot == IDX_W'(g)) ent_q[g].regs_ok <= 1'b1;
                if (wake_vec[g]) ent_q[g].dep_ok <= 1'b1;
                if (nsr_valid && nsr_slot == IDX_W'(g)) ent_q[g].ns_go <= 1'b1;
                if (rdy_fire && rdy_idx == IDX_W'(g)) ent_q[g].sent <= 1'b1;
            end
        end
    end

    // Squash checker state: remember the last squash taken without an insert.
    logic             sqc_v;
    logic [TID_W-1:0] sqc_tid;
    logic [SEQ_W-1:0] sqc_seq;
    logic             sqc_left;

    // Record the squash point for the one-cycle-later survivor check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sqc_v   <= 1'b0;
            sqc_tid <= '0;
            sqc_seq <= '0;
        end else begin
            sqc_v   <= sq_valid && !ins_fire;
            sqc_tid <= sq_tid;
            sqc_seq <= sq_seq;
        end
    end

    // Any live entry that the recorded squash should have removed.
    always_comb begin
        sqc_left = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            if (ent_q[i].live && tid_q[i] == sqc_tid && seq_q[i] > sqc_seq) sqc_left = 1'b1;
        end
    end

    // R9
    squash_leaves_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sqc_v |-> !sqc_left);

    // R2
    insert_occupies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_fire |=> live_vec[$past(free_idx)]);

    // R2
    full_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_full && !cmp_valid && !sq_valid) |=> ins_full);

    // R11
    offer_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_valid && !rdy_accept && !sq_valid && !cmp_valid) |=> rdy_valid);

    // R11
    offer_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_fire |=> !(rdy_valid && rdy_slot == $past(rdy_slot)));

endmodule

// File: tb/test_memdep_tracker.sv
module test_memdep_tracker;

    localparam int SLOTS = 16;
    localparam int SEQ_W = 16;
    localparam int TID_W = 2;
    localparam int IDX_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ins_valid = 0, ins_nonspec = 0, ins_regs_ok = 0;
    logic [1:0]       ins_kind = 0;
    logic [SEQ_W-1:0] ins_seq = 0, ins_pred_seq = 0, sq_seq = 0;
    logic [TID_W-1:0] ins_tid = 0, sq_tid = 0;
    logic             regs_valid = 0, nsr_valid = 0, cmp_valid = 0, sq_valid = 0;
    logic [IDX_W-1:0] regs_slot = 0, nsr_slot = 0, cmp_slot = 0;
    logic             rdy_accept = 0;
    logic             ins_full, rdy_valid;
    logic [IDX_W-1:0] ins_slot, rdy_slot;
    logic [SEQ_W-1:0] rdy_seq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    memdep_tracker #(.SLOTS(SLOTS), .SEQ_W(SEQ_W), .TID_W(TID_W)) i_memdep_tracker (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_kind(ins_kind), .ins_nonspec(ins_nonspec),
        .ins_seq(ins_seq), .ins_tid(ins_tid), .ins_pred_seq(ins_pred_seq),
        .ins_regs_ok(ins_regs_ok), .ins_full(ins_full), .ins_slot(ins_slot),
        .regs_valid(regs_valid), .regs_slot(regs_slot),
        .nsr_valid(nsr_valid), .nsr_slot(nsr_slot),
        .cmp_valid(cmp_valid), .cmp_slot(cmp_slot),
        .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_seq(sq_seq),
        .rdy_valid(rdy_valid), .rdy_accept(rdy_accept),
        .rdy_slot(rdy_slot), .rdy_seq(rdy_seq)
    );

    // Advance one edge; inputs are driven and outputs read 2 ns after it.
    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_ins(int kind, bit ns, int seq, int tid, int pred, bit rok);
        ins_valid = 1; ins_kind = 2'(kind); ins_nonspec = ns; ins_seq = SEQ_W'(seq);
        ins_tid = TID_W'(tid); ins_pred_seq = SEQ_W'(pred); ins_regs_ok = rok;
        cyc();
        ins_valid = 0;
    endtask

    task automatic do_regs(int s);
        regs_valid = 1; regs_slot = IDX_W'(s); cyc(); regs_valid = 0;
    endtask

    task automatic do_cmp(int s);
        cmp_valid = 1; cmp_slot = IDX_W'(s); cyc(); cmp_valid = 0;
    endtask

    task automatic do_nsr(int s);
        nsr_valid = 1; nsr_slot = IDX_W'(s); cyc(); nsr_valid = 0;
    endtask

    task automatic do_sq(int tid, int seq);
        sq_valid = 1; sq_tid = TID_W'(tid); sq_seq = SEQ_W'(seq); cyc(); sq_valid = 0;
    endtask

    // Expect an offer of (slot, seq), then take it.
    task automatic pop(string req, int s, int seq);
        check(req, "rdy_valid", int'(rdy_valid), 1);
        check(req, "rdy_slot", int'(rdy_slot), s);
        check(req, "rdy_seq", int'(rdy_seq), seq);
        rdy_accept = 1; cyc(); rdy_accept = 0;
    endtask

    task automatic t_reset();
        check("R1", "rdy_valid", int'(rdy_valid), 0);
        check("R1", "ins_full", int'(ins_full), 0);
        check("R1", "ins_slot", int'(ins_slot), 0);
    endtask

    task automatic t_independent();
        do_ins(0, 0, 10, 0, 0, 1);
        pop("R5", 0, 10);
        check("R11", "offered once", int'(rdy_valid), 0);
        do_cmp(0);
    endtask

    task automatic t_regs_last();
        do_ins(1, 0, 20, 0, 0, 1);
        pop("R5", 0, 20);
        do_ins(0, 0, 21, 0, 20, 0);
        do_regs(1);
        check("R5", "waits on producer", int'(rdy_valid), 0);
        do_cmp(0);
        pop("R6", 1, 21);
        do_cmp(1);
    endtask

    task automatic t_wake_first();
        do_ins(1, 0, 30, 0, 0, 1);
        pop("R5", 0, 30);
        do_ins(0, 0, 31, 0, 30, 0);
        do_cmp(0);
        check("R6", "woken but regs missing", int'(rdy_valid), 0);
        do_regs(1);
        pop("R5", 1, 31);
        do_cmp(1);
    endtask

    task automatic t_missing_producer();
        do_ins(0, 0, 40, 0, 99, 1);
        pop("R4", 0, 40);
        do_cmp(0);
    endtask

    task automatic t_full_barrier();
        do_ins(2, 0, 50, 0, 0, 0);
        do_ins(0, 0, 51, 0, 0, 1);
        do_ins(1, 0, 52, 0, 0, 1);
        check("R7", "full barrier holds load and store", int'(rdy_valid), 0);
        do_cmp(0);
        pop("R3", 1, 51);
        pop("R3", 2, 52);
        do_ins(0, 0, 53, 0, 0, 1);
        pop("R8", 0, 53);
        do_cmp(0); do_cmp(1); do_cmp(2);
    endtask

    task automatic t_write_barrier();
        do_ins(3, 0, 60, 0, 0, 0);
        do_ins(0, 0, 61, 0, 0, 1);
        do_ins(1, 0, 62, 0, 0, 1);
        pop("R7", 1, 61);
        check("R7", "write barrier holds store", int'(rdy_valid), 0);
        do_cmp(0);
        pop("R3", 2, 62);
        do_cmp(1); do_cmp(2);
    endtask

    task automatic t_barrier_mismatch();
        do_ins(2, 0, 70, 0, 0, 0);
        do_ins(3, 0, 71, 0, 0, 0);
        do_cmp(0);
        do_ins(0, 0, 72, 0, 0, 1);
        do_ins(1, 0, 73, 0, 0, 1);
        pop("R8", 0, 72);
        check("R8", "store barrier kept by newer owner", int'(rdy_valid), 0);
        do_cmp(1);
        pop("R8", 2, 73);
        do_cmp(0); do_cmp(2);
    endtask

    task automatic t_nonspec();
        do_ins(2, 0, 80, 0, 0, 0);
        do_ins(0, 1, 81, 0, 0, 1);
        check("R10", "nonspec waits", int'(rdy_valid), 0);
        do_nsr(1);
        pop("R10", 1, 81);
        do_cmp(0); do_cmp(1);
    endtask

    task automatic t_squash();
        do_ins(0, 0, 90, 0, 0, 0);
        do_ins(0, 0, 91, 0, 0, 0);
        do_ins(0, 0, 92, 1, 0, 0);
        do_sq(0, 90);
        check("R9", "freed slot reused", int'(ins_slot), 1);
        do_regs(0); do_regs(1); do_regs(2);
        pop("R9", 0, 90);
        pop("R9", 2, 92);
        check("R9", "squashed entry gone", int'(rdy_valid), 0);
        do_cmp(0); do_cmp(2);
    endtask

    task automatic t_same_cycle();
        do_ins(1, 0, 110, 0, 0, 1);
        pop("R4", 0, 110);
        cmp_valid = 1; cmp_slot = 0;
        ins_valid = 1; ins_kind = 0; ins_nonspec = 0; ins_seq = 111; ins_tid = 0;
        ins_pred_seq = 110; ins_regs_ok = 1;
        check("R12", "completing slot not reused", int'(ins_slot), 1);
        cyc();
        cmp_valid = 0; ins_valid = 0;
        pop("R4", 1, 111);
        do_cmp(1);
        do_ins(1, 0, 120, 0, 0, 1);
        pop("R5", 0, 120);
        do_ins(0, 0, 121, 0, 120, 0);
        cmp_valid = 1; cmp_slot = 0; regs_valid = 1; regs_slot = 1;
        cyc();
        cmp_valid = 0; regs_valid = 0;
        pop("R6", 1, 121);
        do_cmp(1);
        check("R12", "slot 0 free again", int'(ins_slot), 0);
    endtask

    task automatic t_fill();
        for (int k = 0; k < SLOTS; k++) do_ins(0, 0, 200 + k, 0, 0, 0);
        check("R2", "ins_full", int'(ins_full), 1);
        do_ins(0, 0, 300, 0, 0, 1);
        check("R2", "insert while full ignored", int'(rdy_valid), 0);
        do_regs(15);
        pop("R2", 15, 215);
        do_sq(0, 199);
        check("R2", "ins_full after squash", int'(ins_full), 0);
        check("R2", "ins_slot after squash", int'(ins_slot), 0);
    endtask

    task automatic t_hold();
        do_ins(0, 0, 130, 0, 0, 1);
        for (int k = 0; k < 3; k++) begin
            check("R11", "held valid", int'(rdy_valid), 1);
            check("R11", "held slot", int'(rdy_slot), 0);
            cyc();
        end
        do_ins(0, 0, 131, 0, 0, 1);
        pop("R11", 0, 130);
        pop("R11", 1, 131);
        do_cmp(0); do_cmp(1);
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1;
        t_reset();
        t_independent();
        t_regs_last();
        t_wake_first();
        t_missing_producer();
        t_full_barrier();
        t_write_barrier();
        t_barrier_mismatch();
        t_nonspec();
        t_squash();
        t_same_cycle();
        t_fill();
        t_hold();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule